// File: doc/BRIEF.md
# Card Fault Priority Encoder

This block watches nine active-low diagnostic error lines that come from the common cards of a multiplexer/demultiplexer shelf. Among the lines that are active, it picks the one with the highest priority. From that line it produces a 3-bit select code and a group flag. It also drives a card-fail alarm toward the sequencer and an error lamp for the multiplexer card. Three of the lines report timing-class faults: multiplexer loss of timing, demultiplexer loss of timing, and out-of-timing. These never raise the card-fail alarm. The group flag is high only for multiplexer loss of timing.

Each error line has a fixed card location between 0 and 63. The block converts the location of the selected fault into a two-digit BCD address for a front-panel display. The units digit has weights 1, 2, 4 and 8. The tens digit has weights 1 and 2. Locations of 40 and above cannot be shown, so they blank the display.

A test-polarity input inverts every error line before priority selection. The same input also inverts the lamp output, so the whole alarm path can be exercised from the shelf. All outputs are registered.

Top module: `card_fault_encoder`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: Line i counts as active when `err_n[i] ^ test_inv` is 0. With `test_inv` = 0 a line is active low; with `test_inv` = 1 a line is active high.
- R3: When several lines are active, the lowest index wins.
- R4: The select code follows the winning line. Line 0 gives 111, line 1 gives 110, line 2 gives 101, and lines 3 to 8 give 010. With no line active the code is 000.
- R5: `grp_sel` is 1 only when line 0 wins. It is 0 for every other line and when no line is active.
- R6: `card_fail` is 1 exactly when the registered select code is 010. It is therefore 0 for lines 0, 1 and 2.
- R7: `card_lamp` equals `card_fail` XOR the `test_inv` value sampled on the same edge.
- R8: The card locations of lines 0 to 8 are 39, 20, 9, 12, 19, 27, 5, 31 and 40. A displayable location L appears as `tens_bcd` = L/10 and `units_bcd` = L mod 10, with `disp_blank` = 0.
- R9: A location of 40 or more gives `disp_blank` = 1, with `units_bcd` and `tens_bcd` both 0.
- R10: When no line is active, the select code, `card_fail`, `disp_blank`, `units_bcd` and `tens_bcd` are all 0.
- R11: Every output reflects the inputs sampled at the previous rising clock edge. The latency is exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_n | input | 9 | Error lines, active low in normal mode |
| test_inv | input | 1 | Test polarity: inverts the error lines and the lamp |
| sel_code | output | 3 | Select code of the winning error |
| grp_sel | output | 1 | Group flag, high only for multiplexer loss of timing |
| card_fail | output | 1 | Card-fail alarm to the sequencer |
| card_lamp | output | 1 | Multiplexer-card error lamp drive |
| units_bcd | output | 4 | Units digit of the card address (BCD) |
| tens_bcd | output | 2 | Tens digit of the card address (BCD) |
| disp_blank | output | 1 | Display blanked because the location is out of range |

## Verification
Every result of this block comes out of one register stage. A change on `err_n` or `test_inv` therefore reaches the select code, the alarm, the lamp and the BCD digits on the first rising edge after it. The bench drives inputs on falling edges and samples outputs on the next falling edge, so exactly one rising edge lies between stimulus and check. A dedicated latency test looks just before that edge, where the old result must still be present, and just after it, where the new result must appear. This shows the delay is neither zero nor two cycles.

// File: rtl/card_fault_encoder.sv
module card_fault_encoder #(
  parameter int LINES     = 9,
  parameter int LOC_W     = 6,
  parameter int LOC_LIMIT = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] err_n,
  input  logic             test_inv,
  output logic [2:0]       sel_code,
  output logic             grp_sel,
  output logic             card_fail,
  output logic             card_lamp,
  output logic [3:0]       units_bcd,
  output logic [1:0]       tens_bcd,
  output logic             disp_blank
);
  localparam int IDX_W = $clog2(LINES);

  logic [LINES-1:0] act;
  logic             hit;
  logic [IDX_W-1:0] win;
  logic [2:0]       code_d;
  logic [LOC_W-1:0] loc;
  logic [LOC_W-1:0] rem;
  logic [1:0]       tens_d;
  logic             blank_d;

  assign act = ~(err_n ^ {LINES{test_inv}});

  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (act[i]) begin
        hit = 1'b1;
        win = IDX_W'(i);
      end
    end
  end

  always_comb begin
    case (win)
      IDX_W'(0): begin code_d = 3'b111; loc = LOC_W'(39); end
      IDX_W'(1): begin code_d = 3'b110; loc = LOC_W'(20); end
      IDX_W'(2): begin code_d = 3'b101; loc = LOC_W'(9);  end
      IDX_W'(3): begin code_d = 3'b010; loc = LOC_W'(12); end
      IDX_W'(4): begin code_d = 3'b010; loc = LOC_W'(19); end
      IDX_W'(5): begin code_d = 3'b010; loc = LOC_W'(27); end
      IDX_W'(6): begin code_d = 3'b010; loc = LOC_W'(5);  end
      IDX_W'(7): begin code_d = 3'b010; loc = LOC_W'(31); end
      IDX_W'(8): begin code_d = 3'b010; loc = LOC_W'(40); end
      default:   begin code_d = 3'b010; loc = LOC_W'(0);  end
    endcase
    if (!hit) begin
      code_d = 3'b000;
      loc    = '0;
    end
  end

  always_comb begin
    blank_d = (loc >= LOC_W'(LOC_LIMIT));
    if (loc >= LOC_W'(30)) begin
      tens_d = 2'd3; rem = loc - LOC_W'(30);
    end else if (loc >= LOC_W'(20)) begin
      tens_d = 2'd2; rem = loc - LOC_W'(20);
    end else if (loc >= LOC_W'(10)) begin
      tens_d = 2'd1; rem = loc - LOC_W'(10);
    end else begin
      tens_d = 2'd0; rem = loc;
    end
  end

  wire fail_d = (code_d == 3'b010);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_code   <= '0;
      grp_sel    <= 1'b0;
      card_fail  <= 1'b0;
      card_lamp  <= 1'b0;
      units_bcd  <= '0;
      tens_bcd   <= '0;
      disp_blank <= 1'b0;
    end else begin
      sel_code   <= code_d;
      grp_sel    <= hit && (win == '0);
      card_fail  <= fail_d;
      card_lamp  <= fail_d ^ test_inv;
      units_bcd  <= blank_d ? 4'd0 : rem[3:0];
      tens_bcd   <= blank_d ? 2'd0 : tens_d;
      disp_blank <= blank_d;
    end
  end
endmodule

// File: rtl/card_fault_encoder_chk.sv
module card_fault_encoder_chk #(
  parameter int LINES = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LINES-1:0] err_n,
  input logic             test_inv,
  input logic [2:0]       sel_code,
  input logic             grp_sel,
  input logic             card_fail,
  input logic             card_lamp,
  input logic [3:0]       units_bcd,
  input logic [1:0]       tens_bcd,
  input logic             disp_blank
);
  a_r5_grp_only_mux_lot: assert property (@(posedge clk) disable iff (!rst_n)
    grp_sel |-> (sel_code == 3'b111));

  a_r6_fail_needs_code: assert property (@(posedge clk) disable iff (!rst_n)
    card_fail |-> (sel_code == 3'b010));

  a_r6_timing_no_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_code[2] == 1'b1) |-> !card_fail);

  a_r7_lamp_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (card_lamp == (card_fail ^ $past(test_inv))));

  a_r8_units_is_bcd: assert property (@(posedge clk) disable iff (!rst_n)
    units_bcd <= 4'd9);

  a_r9_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    disp_blank |-> (units_bcd == 4'd0 && tens_bcd == 2'd0));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&(err_n ^ {LINES{test_inv}})) |=>
      (sel_code == 3'b000 && !card_fail && !disp_blank && units_bcd == 4'd0 && tens_bcd == 2'd0));
endmodule

bind card_fault_encoder card_fault_encoder_chk #(.LINES(LINES)) u_chk (.*);

// File: tb/card_fault_encoder_bench.sv
module card_fault_encoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] err_n = 9'h1FF;
  logic       test_inv = 1'b0;
  logic [2:0] sel_code;
  logic       grp_sel, card_fail, card_lamp, disp_blank;
  logic [3:0] units_bcd;
  logic [1:0] tens_bcd;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  card_fault_encoder u_card_fault_encoder (
    .clk(clk), .rst_n(rst_n), .err_n(err_n), .test_inv(test_inv),
    .sel_code(sel_code), .grp_sel(grp_sel), .card_fail(card_fail),
    .card_lamp(card_lamp), .units_bcd(units_bcd), .tens_bcd(tens_bcd),
    .disp_blank(disp_blank)
  );

  // {inv, err_n, sel, grp, fail, lamp, units, tens, blank}
  localparam logic [22:0] VEC [16] = '{
    {1'b0, 9'h1FF, 3'b000, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, 1'b0},
    {1'b0, 9'h1FE, 3'b111, 1'b1, 1'b0, 1'b0, 4'd9, 2'd3, 1'b0},
    {1'b0, 9'h1FD, 3'b110, 1'b0, 1'b0, 1'b0, 4'd0, 2'd2, 1'b0},
    {1'b0, 9'h1FB, 3'b101, 1'b0, 1'b0, 1'b0, 4'd9, 2'd0, 1'b0},
    {1'b0, 9'h1F7, 3'b010, 1'b0, 1'b1, 1'b1, 4'd2, 2'd1, 1'b0},
    {1'b0, 9'h1EF, 3'b010, 1'b0, 1'b1, 1'b1, 4'd9, 2'd1, 1'b0},
    {1'b0, 9'h1DF, 3'b010, 1'b0, 1'b1, 1'b1, 4'd7, 2'd2, 1'b0},
    {1'b0, 9'h1BF, 3'b010, 1'b0, 1'b1, 1'b1, 4'd5, 2'd0, 1'b0},
    {1'b0, 9'h17F, 3'b010, 1'b0, 1'b1, 1'b1, 4'd1, 2'd3, 1'b0},
    {1'b0, 9'h0FF, 3'b010, 1'b0, 1'b1, 1'b1, 4'd0, 2'd0, 1'b1},
    {1'b0, 9'h1DB, 3'b101, 1'b0, 1'b0, 1'b0, 4'd9, 2'd0, 1'b0},
    {1'b0, 9'h0EF, 3'b010, 1'b0, 1'b1, 1'b1, 4'd9, 2'd1, 1'b0},
    {1'b0, 9'h000, 3'b111, 1'b1, 1'b0, 1'b0, 4'd9, 2'd3, 1'b0},
    {1'b1, 9'h000, 3'b000, 1'b0, 1'b0, 1'b1, 4'd0, 2'd0, 1'b0},
    {1'b1, 9'h008, 3'b010, 1'b0, 1'b1, 1'b0, 4'd2, 2'd1, 1'b0},
    {1'b1, 9'h1FF, 3'b111, 1'b1, 1'b0, 1'b1, 4'd9, 2'd3, 1'b0}
  };

  function automatic logic [12:0] outs();
    return {sel_code, grp_sel, card_fail, card_lamp, units_bcd, tens_bcd, disp_blank};
  endfunction

  task automatic check(input string req, input logic [12:0] exp);
    total++;
    if (outs() !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, outs(), exp);
    end
  endtask

  task automatic apply(input logic inv, input logic [8:0] e);
    @(negedge clk);
    test_inv = inv;
    err_n    = e;
    @(negedge clk);
  endtask

  initial begin
    // R1: reset state with an active error present
    err_n = 9'h000;
    repeat (3) @(negedge clk);
    check("R1 reset", 13'd0);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R6 R7 R8 R9 R10: vector walk
    for (int i = 0; i < 16; i++) begin
      apply(VEC[i][22], VEC[i][21:13]);
      check($sformatf("R2 R3 R4 R5 R6 R7 R8 R9 R10 vec%0d", i), VEC[i][12:0]);
    end

    // R11: exactly one cycle of latency
    apply(1'b0, 9'h1FF);
    @(negedge clk);
    err_n = 9'h1F7;
    @(posedge clk);
    #1;
    check("R11 after first edge", {3'b010, 1'b0, 1'b1, 1'b1, 4'd2, 2'd1, 1'b0});
    @(negedge clk);
    err_n = 9'h1FE;
    #8;
    check("R11 before edge holds old", {3'b010, 1'b0, 1'b1, 1'b1, 4'd2, 2'd1, 1'b0});

    // R9: blanked location clears when a displayable one follows
    apply(1'b0, 9'h0FF);
    check("R9 blank", {3'b010, 1'b0, 1'b1, 1'b1, 4'd0, 2'd0, 1'b1});
    apply(1'b0, 9'h1BF);
    check("R8 after blank", {3'b010, 1'b0, 1'b1, 1'b1, 4'd5, 2'd0, 1'b0});

    // R1: reset applied mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check("R1 mid-run reset", 13'd0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(1'b0, 9'h1FF);
    check("R10 idle after reset", 13'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule